// File: doc/BRIEF.md
# ADC Calibration Sequencing Controller

This block is the digital sequencer that steps a sigma-delta converter through its calibration and conversion phases. A host writes a 3-bit mode code. The block then walks a fixed timeline measured in output-rate periods. An input pulse marks the end of each period, and a separate strobe marks each modulator cycle. The block reports its current phase on a selector. It pulses one of three load strobes, for the offset coefficient, the gain coefficient or the data word, when a phase completes. It also drives an active-low data-ready flag.

Two calibration flows are built in. The system-offset flow runs a zero-scale phase on the external input, then a full-scale phase on the internal reference. After that the mode field clears itself and one settling conversion runs. The background flow alternates a settling conversion with a zero-scale self-calibration for as long as its code stays written. Any other code selects plain continuous conversion. The filter, the modulator and the coefficient arithmetic are outside the block. The period pulses and the load strobes stand in for them.

Top module: `cal_seq_ctrl`

## Requirements
- R1: A synchronous active-high reset sets `mode_q` to 000 and `phase_sel` to idle (code 0), forces `drdy_n` high and clears all load strobes. In idle, period pulses are ignored.
- R2: Writing code 100 selects phase code 1 (zero-scale system) from the next cycle. That phase spans 3 period pulses. In the cycle after the third pulse, `ld_offset` is high for one cycle and the phase becomes code 3 (full-scale self).
- R3: The full-scale self phase spans 3 period pulses. In the cycle after the sixth pulse since the write, `ld_gain` pulses and `mode_q` reads 000.
- R4: After the full-scale phase, a conversion (phase code 4) spans 3 period pulses. In the cycle after the ninth pulse, `ld_data` pulses and `drdy_n` goes low. `drdy_n` falls only together with `ld_data`.
- R5: After any mode write, `drdy_n` goes high at the first clock edge where `mod_tick` is sampled high, not counting the write cycle itself. It then stays high until the next data load. If a data load comes first, the pending rise is dropped.
- R6: In any cycle at most one of `ld_offset`, `ld_gain` and `ld_data` is high. Each load happens only in the cycle after the period pulse that ends a phase.
- R7: Code 101 runs a conversion of 3 pulses, which ends with `ld_data`. It then runs a zero-scale self phase (code 2) of 3 pulses, which ends with `ld_offset`. This repeats, giving one data word per 6 pulses and never `ld_gain`.
- R8: While code 101 is held, `mode_q` keeps reading 101 until the host writes another code.
- R9: Any code other than 100 and 101 runs continuous conversion. The first word loads after 3 period pulses and each later word after every single pulse. Conversion after the system-offset flow behaves the same way.
- R10: A mode write aborts the running sequence and restarts the timeline at the first phase of the new code. A period pulse in the same cycle as the write is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | One-cycle write strobe for the mode field |
| mode_wdata | input | 3 | Mode code being written |
| period_tick | input | 1 | Pulse marking the end of an output-rate period |
| mod_tick | input | 1 | Pulse marking a modulator cycle |
| mode_q | output | 3 | Current mode field |
| phase_sel | output | 3 | Phase: 0 idle, 1 zero-scale system, 2 zero-scale self, 3 full-scale self, 4 conversion |
| ld_offset | output | 1 | Offset coefficient load strobe |
| ld_gain | output | 1 | Gain coefficient load strobe |
| ld_data | output | 1 | Data word load strobe |
| drdy_n | output | 1 | Data-ready flag, active low |

## Verification
A wrong phase or a miscounted period register shows on `phase_sel` in the cycle after the period pulse where it goes astray. A strobe then appears one period early or late, or goes missing. A mode register that fails to self-clear or to hold shows on `mode_q` at once. A lost rise request on data-ready stays hidden until the next modulator strobe and only then shows as a low `drdy_n`. A behavioural model counts elapsed periods from each write and compares every output on every clock, so each of these faults surfaces within one cycle of its first visible effect.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

   localparam int unsigned MODE_W = 3;

   localparam logic [MODE_W-1:0] MODE_SYS_OFS = 3'b100;
   localparam logic [MODE_W-1:0] MODE_BG      = 3'b101;
   localparam logic [MODE_W-1:0] MODE_NONE    = 3'b000;

   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_ZS_SYS  = 3'd1,
      PH_ZS_SELF = 3'd2,
      PH_FS_SELF = 3'd3,
      PH_CONV    = 3'd4
   } phase_e;

   typedef enum logic [1:0] {
      LEN_CAL    = 2'd0,
      LEN_SETTLE = 2'd1,
      LEN_ONE    = 2'd2
   } len_sel_e;

endpackage

// File: rtl/cal_period_timer.sv
module cal_period_timer
   import cal_seq_pkg::*;
#(
   parameter int unsigned CAL_PERIODS    = 3,
   parameter int unsigned SETTLE_PERIODS = 3
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     restart,
   input  logic     active,
   input  logic     period_tick,
   input  len_sel_e len_sel,
   output logic     phase_end
);

   localparam int unsigned MAX_P = (CAL_PERIODS > SETTLE_PERIODS) ? CAL_PERIODS : SETTLE_PERIODS;
   localparam int unsigned CNT_W = $clog2(MAX_P + 1);

   localparam logic [CNT_W-1:0] LAST_CAL    = CNT_W'(CAL_PERIODS - 1);
   localparam logic [CNT_W-1:0] LAST_SETTLE = CNT_W'(SETTLE_PERIODS - 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last_val;
   logic             at_last;

   always_comb begin
      unique case (len_sel)
         LEN_CAL:    last_val = LAST_CAL;
         LEN_SETTLE: last_val = LAST_SETTLE;
         default:    last_val = '0;
      endcase
   end

   assign at_last   = (cnt == last_val);
   assign phase_end = active && period_tick && !restart && at_last;

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         cnt <= '0;
      end else if (active && period_tick) begin
         cnt <= at_last ? '0 : cnt + 1'b1;
      end
   end

endmodule

// File: rtl/cal_seq_fsm.sv
module cal_seq_fsm
   import cal_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              mode_wr,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic              phase_end,
   output logic [MODE_W-1:0] mode_q,
   output phase_e            phase,
   output len_sel_e          len_sel,
   output logic              active,
   output logic              data_end,
   output logic              ld_offset,
   output logic              ld_gain,
   output logic              ld_data
);

   logic settled;

   assign active   = (phase != PH_IDLE);
   assign data_end = phase_end && (phase == PH_CONV);

   always_comb begin
      if (phase == PH_CONV) begin
         len_sel = settled ? LEN_ONE : LEN_SETTLE;
      end else begin
         len_sel = LEN_CAL;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q    <= MODE_NONE;
         phase     <= PH_IDLE;
         settled   <= 1'b0;
         ld_offset <= 1'b0;
         ld_gain   <= 1'b0;
         ld_data   <= 1'b0;
      end else begin
         ld_offset <= 1'b0;
         ld_gain   <= 1'b0;
         ld_data   <= 1'b0;
         if (mode_wr) begin
            mode_q  <= mode_wdata;
            settled <= 1'b0;
            phase   <= (mode_wdata == MODE_SYS_OFS) ? PH_ZS_SYS : PH_CONV;
         end else if (phase_end) begin
            unique case (phase)
               PH_ZS_SYS: begin
                  ld_offset <= 1'b1;
                  phase     <= PH_FS_SELF;
               end
               PH_FS_SELF: begin
                  ld_gain <= 1'b1;
                  mode_q  <= MODE_NONE;
                  settled <= 1'b0;
                  phase   <= PH_CONV;
               end
               PH_CONV: begin
                  ld_data <= 1'b1;
                  if (mode_q == MODE_BG) begin
                     phase <= PH_ZS_SELF;
                  end else begin
                     settled <= 1'b1;
                  end
               end
               PH_ZS_SELF: begin
                  ld_offset <= 1'b1;
                  settled   <= 1'b0;
                  phase     <= PH_CONV;
               end
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/cal_drdy_ctl.sv
module cal_drdy_ctl #(
   parameter bit WAIT_MOD = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic mode_wr,
   input  logic data_end,
   input  logic mod_tick,
   output logic drdy_n
);

   generate
      if (WAIT_MOD) begin : g_wait_mod
         logic rise_pend;
         always_ff @(posedge clk) begin
            if (rst) begin
               drdy_n    <= 1'b1;
               rise_pend <= 1'b0;
            end else if (mode_wr) begin
               rise_pend <= 1'b1;
            end else if (data_end) begin
               drdy_n    <= 1'b0;
               rise_pend <= 1'b0;
            end else if (mod_tick && rise_pend) begin
               drdy_n    <= 1'b1;
               rise_pend <= 1'b0;
            end
         end
      end else begin : g_immediate
         always_ff @(posedge clk) begin
            if (rst || mode_wr) begin
               drdy_n <= 1'b1;
            end else if (data_end) begin
               drdy_n <= 1'b0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
   import cal_seq_pkg::*;
#(
   parameter int unsigned CAL_PERIODS    = 3,
   parameter int unsigned SETTLE_PERIODS = 3,
   parameter bit          DRDY_WAIT_MOD  = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       mode_wr,
   input  logic [2:0] mode_wdata,
   input  logic       period_tick,
   input  logic       mod_tick,
   output logic [2:0] mode_q,
   output logic [2:0] phase_sel,
   output logic       ld_offset,
   output logic       ld_gain,
   output logic       ld_data,
   output logic       drdy_n
);

   generate
      if (CAL_PERIODS < 1) begin : g_bad_cal
         $error("CAL_PERIODS must be at least 1");
      end
      if (SETTLE_PERIODS < 1) begin : g_bad_settle
         $error("SETTLE_PERIODS must be at least 1");
      end
   endgenerate

   phase_e   phase;
   len_sel_e len_sel;
   logic     active;
   logic     phase_end;
   logic     data_end;

   cal_period_timer #(
      .CAL_PERIODS    (CAL_PERIODS),
      .SETTLE_PERIODS (SETTLE_PERIODS)
   ) u_timer (
      .clk         (clk),
      .rst         (rst),
      .restart     (mode_wr),
      .active      (active),
      .period_tick (period_tick),
      .len_sel     (len_sel),
      .phase_end   (phase_end)
   );

   cal_seq_fsm u_fsm (
      .clk        (clk),
      .rst        (rst),
      .mode_wr    (mode_wr),
      .mode_wdata (mode_wdata),
      .phase_end  (phase_end),
      .mode_q     (mode_q),
      .phase      (phase),
      .len_sel    (len_sel),
      .active     (active),
      .data_end   (data_end),
      .ld_offset  (ld_offset),
      .ld_gain    (ld_gain),
      .ld_data    (ld_data)
   );

   cal_drdy_ctl #(
      .WAIT_MOD (DRDY_WAIT_MOD)
   ) u_drdy (
      .clk      (clk),
      .rst      (rst),
      .mode_wr  (mode_wr),
      .data_end (data_end),
      .mod_tick (mod_tick),
      .drdy_n   (drdy_n)
   );

   assign phase_sel = phase;

endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk
   import cal_seq_pkg::*;
#(
   parameter bit WAIT_MOD = 1'b1
) (
   input logic       clk,
   input logic       rst,
   input logic       mode_wr,
   input logic [2:0] mode_wdata,
   input logic       mod_tick,
   input logic [2:0] mode_q,
   input logic [2:0] phase_sel,
   input logic       ld_offset,
   input logic       ld_gain,
   input logic       ld_data,
   input logic       drdy_n
);

   logic rst_q = 1'b0;

   always_ff @(posedge clk) rst_q <= rst;

   always @(posedge clk) begin
      if (rst_q) begin
         AST_RST_CLEAR: assert (mode_q == 3'b000 && phase_sel == 3'd0 && drdy_n &&
                                !ld_offset && !ld_gain && !ld_data); // R1
      end
   end

   AST_SYS_START: assert property (@(posedge clk) disable iff (rst)
      (mode_wr && mode_wdata == MODE_SYS_OFS) |=> (phase_sel == 3'd1 && mode_q == MODE_SYS_OFS)); // R2

   AST_MODE_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
      ld_gain |-> (mode_q == 3'b000)); // R3

   AST_DRDY_FALL_DATA: assert property (@(posedge clk) disable iff (rst)
      $fell(drdy_n) |-> ld_data); // R4

   AST_DATA_DRDY_LOW: assert property (@(posedge clk) disable iff (rst)
      ld_data |-> !drdy_n); // R4

   generate
      if (WAIT_MOD) begin : g_mod_rise
         AST_DRDY_RISE_MOD: assert property (@(posedge clk) disable iff (rst)
            ($rose(drdy_n) && !$past(rst)) |-> $past(mod_tick)); // R5
      end
   endgenerate

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
      $countones({ld_offset, ld_gain, ld_data}) <= 1); // R6

   AST_BG_NO_GAIN: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_BG) |-> !ld_gain); // R7

   AST_BG_HOLD: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_BG && !mode_wr) |=> (mode_q == MODE_BG)); // R8

   AST_WR_RESTART: assert property (@(posedge clk) disable iff (rst)
      (mode_wr && mode_wdata != MODE_SYS_OFS) |=> (phase_sel == 3'd4 && mode_q == $past(mode_wdata))); // R10

endmodule

bind cal_seq_ctrl cal_seq_chk #(
   .WAIT_MOD (DRDY_WAIT_MOD)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .mode_wr    (mode_wr),
   .mode_wdata (mode_wdata),
   .mod_tick   (mod_tick),
   .mode_q     (mode_q),
   .phase_sel  (phase_sel),
   .ld_offset  (ld_offset),
   .ld_gain    (ld_gain),
   .ld_data    (ld_data),
   .drdy_n     (drdy_n)
);

// File: tb/cal_seq_ctrl_tb.sv
module cal_seq_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       mode_wr = 1'b0;
   logic [2:0] mode_wdata = 3'b000;
   logic       period_tick = 1'b0;
   logic       mod_tick = 1'b0;
   logic [2:0] mode_q;
   logic [2:0] phase_sel;
   logic       ld_offset;
   logic       ld_gain;
   logic       ld_data;
   logic       drdy_n;

   always #5 clk = ~clk;

   cal_seq_ctrl u_dut (
      .clk         (clk),
      .rst         (rst),
      .mode_wr     (mode_wr),
      .mode_wdata  (mode_wdata),
      .period_tick (period_tick),
      .mod_tick    (mod_tick),
      .mode_q      (mode_q),
      .phase_sel   (phase_sel),
      .ld_offset   (ld_offset),
      .ld_gain     (ld_gain),
      .ld_data     (ld_data),
      .drdy_n      (drdy_n)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit armed = 1'b0;
   bit finished = 1'b0;

   // reference model state: sequence kind 0 none, 1 system offset, 2 background, 3 conversion
   int m_seq, m_el, m_mode, m_phase;
   bit m_drdy, m_pend, e_off, e_gain, e_data;
   int n_data, n_off, n_gain;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      armed = 1'b1;
      n_data += int'(ld_data === 1'b1);
      n_off  += int'(ld_offset === 1'b1);
      n_gain += int'(ld_gain === 1'b1);
      e_off = 0; e_gain = 0; e_data = 0;
      if (rst) begin
         m_seq = 0; m_el = 0; m_mode = 0; m_drdy = 1; m_pend = 0;
      end else if (mode_wr) begin
         m_mode = mode_wdata;
         m_seq  = (mode_wdata == 3'b100) ? 1 : (mode_wdata == 3'b101) ? 2 : 3;
         m_el   = 0;
         m_pend = 1;
      end else begin
         if (period_tick && m_seq != 0) begin
            m_el++;
            case (m_seq)
               1: begin
                  if (m_el == 3) e_off = 1;
                  else if (m_el == 6) begin e_gain = 1; m_mode = 0; end
                  else if (m_el >= 9) e_data = 1;
               end
               2: begin
                  if (m_el % 6 == 3) e_data = 1;
                  else if (m_el % 6 == 0) e_off = 1;
               end
               default: if (m_el >= 3) e_data = 1;
            endcase
         end
         if (e_data) begin m_drdy = 0; m_pend = 0; end
         else if (mod_tick && m_pend) begin m_drdy = 1; m_pend = 0; end
      end
      case (m_seq)
         0: m_phase = 0;
         1: m_phase = (m_el < 3) ? 1 : (m_el < 6) ? 3 : 4;
         2: m_phase = (m_el % 6 < 3) ? 4 : 2;
         default: m_phase = 4;
      endcase
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (armed) begin
         chk(phase_sel == 3'(m_phase), "R2 phase_sel", phase_sel, m_phase);
         chk(mode_q == 3'(m_mode), "R3 mode_q", mode_q, m_mode);
         chk({ld_offset, ld_gain, ld_data} == {e_off, e_gain, e_data}, "R6 strobes {off,gain,data}",
             {ld_offset, ld_gain, ld_data}, {e_off, e_gain, e_data});
         chk(drdy_n == m_drdy, "R5 drdy_n", drdy_n, m_drdy);
      end
   end

   task automatic drive(input bit wr, input logic [2:0] code);
      @(negedge clk);
      cyc++;
      period_tick = (cyc % 8 == 0);
      mod_tick    = (cyc % 5 == 3);
      mode_wr     = wr;
      mode_wdata  = code;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 3'b000);
   endtask

   task automatic write(input logic [2:0] code);
      drive(1'b1, code);
   endtask

   task automatic check_reset_state();
      chk(mode_q == 3'b000, "R1 mode_q after reset", mode_q, 0);
      chk(phase_sel == 3'd0, "R1 phase_sel after reset", phase_sel, 0);
      chk(drdy_n == 1'b1, "R1 drdy_n after reset", drdy_n, 1);
      chk({ld_offset, ld_gain, ld_data} == 3'b000, "R1 strobes after reset",
          {ld_offset, ld_gain, ld_data}, 0);
   endtask

   initial begin
      run(3);
      rst = 1'b0;
      run(1);
      check_reset_state();
      run(30);
      chk(phase_sel == 3'd0, "R1 idle ignores period pulses", phase_sel, 0);

      // system-offset calibration
      n_off = 0; n_gain = 0; n_data = 0;
      write(3'b100);
      run(1);
      chk(phase_sel == 3'd1, "R2 zero-scale system phase", phase_sel, 1);
      run(100);
      chk(n_off == 1, "R2 one offset load", n_off, 1);
      chk(n_gain == 1, "R3 one gain load", n_gain, 1);
      chk(mode_q == 3'b000, "R3 mode self-cleared", mode_q, 0);
      chk(drdy_n == 1'b0, "R4 data ready after calibration", drdy_n, 0);

      // continuous conversion afterwards
      n_data = 0;
      run(40);
      chk(n_data == 5, "R9 one word per period", n_data, 5);

      // background mode, written while data-ready is low
      write(3'b101);
      begin
         bit seen = 1'b0;
         for (int i = 0; i < 7; i++) begin
            run(1);
            if (drdy_n) seen = 1'b1;
         end
         chk(seen, "R5 drdy_n rose after write", int'(seen), 1);
      end
      run(150);
      n_off = 0; n_gain = 0; n_data = 0;
      run(96);
      chk(n_data == 2, "R7 words per 12 periods", n_data, 2);
      chk(n_off == 2, "R7 offset loads per 12 periods", n_off, 2);
      chk(n_gain == 0, "R7 no gain loads", n_gain, 0);
      chk(mode_q == 3'b101, "R8 background mode held", mode_q, 5);

      // abort a system calibration with a conversion code
      write(3'b100);
      run(20);
      write(3'b110);
      run(1);
      chk(phase_sel == 3'd4, "R10 restart at conversion", phase_sel, 4);
      chk(mode_q == 3'b110, "R10 new mode code", mode_q, 6);
      n_off = 0; n_gain = 0; n_data = 0;
      run(100);
      chk(n_off == 0 && n_gain == 0, "R10 no calibration loads after abort", n_off + n_gain, 0);
      chk(n_data > 0, "R9 conversion running after abort", n_data, 1);

      // write coinciding with a period pulse
      while ((cyc + 1) % 8 != 0) run(1);
      write(3'b100);
      run(120);
      chk(mode_q == 3'b000, "R10 tick at write not counted, sequence complete", mode_q, 0);

      // reset in the middle of background mode
      write(3'b101);
      run(30);
      rst = 1'b1;
      run(2);
      rst = 1'b0;
      check_reset_state();
      run(5);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule